// File: doc/BRIEF.md
# Vectored Priority Nesting Controller

This block sits after the source-masking stage of an interrupt path. It takes a 32-bit vector of pending normal-class requests and ranks up to sixteen of them through sixteen programmable vector slots. Slot 0 ranks highest. A seventeenth, unvectored level sits below the last slot and catches any pending source that no enabled slot claims. An idle state sits above all of these levels.

The block tracks the level now being serviced. It raises its interrupt output only when a request of strictly higher rank than that level is pending. When the handler entry code reads the vector-address register, the controller acknowledges the best pending level, moves the service level up to it, and saves the old level in a history entry. The read returns the handler address of the level now in service. When the handler exit code writes the vector-address register, the saved level comes back. This gives nested preemption in hardware.

Top module: `vic_nest_ctrl`

## Requirements
- R1: After reset, every slot address, slot control byte and the default address read as zero, the service level is idle, and `irq_o` is low.
- R2: The slot handler addresses sit at byte offsets 0x100 + 4·n and read back the full 32-bit value written. The slot control bytes sit at 0x200 + 4·n and keep only data bits 7:0; the upper bits read as zero. The default handler address sits at 0x034.
- R3: The mask of level L is the OR of the one-hot source bits of every enabled slot numbered below L. `irq_o` is high in the cycle after the pending vector ANDed with the mask of the service level is non-zero. At level 0 the mask is empty, so `irq_o` stays low.
- R4: While idle, any pending source bit, vectored or not, raises `irq_o`.
- R5: A read of offset 0x030 picks the lowest level L, below the service level, at which some pending source belongs to an enabled slot numbered L or lower. Level 16 counts every enabled slot and, when idle, every source. The block makes L the new service level, saves the old level for L, and returns the address of slot L. For level 16 it returns the default address.
- R6: A read of 0x030 while idle with nothing pending returns the default address and leaves the block idle.
- R7: A read of 0x030 when nothing outranks the service level leaves the level unchanged and returns the address of the level in service.
- R8: Any write to 0x030 ignores its data and restores the level saved for the service level. While idle, the write has no effect.
- R9: In a control byte, bit 5 enables the slot and bits 4:0 name its source. A disabled slot ranks nothing. When two enabled slots name one source, the lower-numbered slot wins.
- R10: A write to a slot address or control register changes the masks. `irq_o` follows the new masks one cycle after the write completes.
- R11: Reads of offsets outside the register map return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 32 | Pending normal-class source vector |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Normal interrupt request to the processor |

## Verification
The directed part programs overlapping slots. It then tries several pending patterns: a source owned only by a disabled slot, a source claimed by two slots, a lower-ranked source and then a higher-ranked one, and an all-clear. These patterns separate the unvectored fallback, the rule that the lower-numbered slot wins, preemption against non-preemption, and the default-address response. A mask change made while a level is in service shows the one-cycle delay before the output follows. A random phase mixes pending changes, acknowledge reads, end-of-service writes and slot reprogramming over a small set of sources. This drives deep nesting and unwinding, and each read address and the output level are compared with a reference model kept in the bench.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // Control byte field layout
    localparam int CTL_EN_BIT = 5;

    // Register byte offsets
    localparam logic [15:0] OFS_SLOT_ADDR = 16'h0100;
    localparam logic [15:0] OFS_SLOT_CTL  = 16'h0200;
    localparam logic [15:0] OFS_VEC       = 16'h0030;
    localparam logic [15:0] OFS_DEF       = 16'h0034;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SLOT_ADDR,
        ACC_SLOT_CTL,
        ACC_VEC,
        ACC_DEF
    } acc_e;
endpackage

// File: rtl/vic_addr_dec.sv
module vic_addr_dec
    import vic_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SLOT_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind,
    output logic [SLOT_W-1:0] idx
);
    localparam int HI = SLOT_W + 2;
    localparam logic [ADDR_W-1:0] A_SADDR = ADDR_W'(OFS_SLOT_ADDR);
    localparam logic [ADDR_W-1:0] A_SCTL  = ADDR_W'(OFS_SLOT_CTL);
    localparam logic [ADDR_W-1:0] A_VEC   = ADDR_W'(OFS_VEC);
    localparam logic [ADDR_W-1:0] A_DEF   = ADDR_W'(OFS_DEF);

    always_comb begin
        idx  = addr[HI-1:2];
        kind = ACC_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr[ADDR_W-1:HI] == A_SADDR[ADDR_W-1:HI])
                kind = ACC_SLOT_ADDR;
            else if (addr[ADDR_W-1:HI] == A_SCTL[ADDR_W-1:HI])
                kind = ACC_SLOT_CTL;
            else if (addr == A_VEC)
                kind = ACC_VEC;
            else if (addr == A_DEF)
                kind = ACC_DEF;
        end
    end
endmodule

// File: rtl/vic_mask_gen.sv
module vic_mask_gen
    import vic_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int CTL_W     = 8
) (
    input  logic [NUM_SLOTS-1:0][CTL_W-1:0] ctl,
    output logic [NUM_SLOTS+1:0][SRC_W-1:0] lvl_mask
);
    localparam int SEL_W = $clog2(SRC_W);

    logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_bit;
    logic unused_ctl;
    assign unused_ctl = ^ctl;

    // one-hot source bit for each enabled slot
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_bit[g] = ctl[g][CTL_EN_BIT] ? (SRC_W'(1) << ctl[g][SEL_W-1:0]) : '0;
    end

    // running OR: level L sees slots 0..L-1, idle level sees everything
    always_comb begin
        logic [SRC_W-1:0] acc_d;
        acc_d = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            lvl_mask[i] = acc_d;
            acc_d       = acc_d | slot_bit[i];
        end
        lvl_mask[NUM_SLOTS]   = acc_d;
        lvl_mask[NUM_SLOTS+1] = '1;
    end
endmodule

// File: rtl/vic_level_scan.sv
module vic_level_scan #(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int LVL_W     = 5
) (
    input  logic [SRC_W-1:0]                 pend,
    input  logic [NUM_SLOTS+1:0][SRC_W-1:0]  lvl_mask,
    input  logic [LVL_W-1:0]                 cur,
    output logic [LVL_W-1:0]                 lvl,
    output logic                             hit
);
    // lowest level below cur whose next-level mask meets a pending source
    always_comb begin
        lvl = cur;
        hit = 1'b0;
        for (int i = 0; i <= NUM_SLOTS; i++) begin
            if (!hit && (LVL_W'(i) < cur) && (|(pend & lvl_mask[i+1]))) begin
                hit = 1'b1;
                lvl = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_nest_ctrl.sv
module vic_nest_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SRC_W     = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int CTL_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  pend_i,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int LVL_W  = $clog2(NUM_SLOTS + 2);
    localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SLOTS + 1);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_addr;
        logic [NUM_SLOTS-1:0][CTL_W-1:0]  slot_ctl;
        logic [DATA_W-1:0]                def_addr;
        logic [LVL_W-1:0]                 cur;
        logic [NUM_SLOTS:0][LVL_W-1:0]    hist;
        logic                             irq;
        logic [DATA_W-1:0]                rdata;
    } state_t;

    state_t d, q;

    acc_e                           kind;
    logic [SLOT_W-1:0]              idx;
    logic [NUM_SLOTS+1:0][SRC_W-1:0] lvl_mask;
    logic [LVL_W-1:0]               scan_lvl;
    logic                           scan_hit;
    logic                           rd_en, wr_en, rd_vec, wr_vec;

    assign rd_en  = bus_en && !bus_we;
    assign wr_en  = bus_en && bus_we;
    assign rd_vec = rd_en && (kind == ACC_VEC);
    assign wr_vec = wr_en && (kind == ACC_VEC);

    vic_addr_dec #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) i_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    vic_mask_gen #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .CTL_W(CTL_W)) i_mask (
        .ctl      (q.slot_ctl),
        .lvl_mask (lvl_mask)
    );

    vic_level_scan #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .LVL_W(LVL_W)) i_scan (
        .pend     (pend_i),
        .lvl_mask (lvl_mask),
        .cur      (q.cur),
        .lvl      (scan_lvl),
        .hit      (scan_hit)
    );

    always_comb begin
        logic [LVL_W-1:0] new_lvl;
        d       = q;
        d.rdata = '0;
        d.irq   = |(pend_i & lvl_mask[q.cur]);
        new_lvl = scan_hit ? scan_lvl : q.cur;
        case (kind)
            ACC_SLOT_ADDR: begin
                if (wr_en) d.slot_addr[idx] = bus_wdata;
                if (rd_en) d.rdata = q.slot_addr[idx];
            end
            ACC_SLOT_CTL: begin
                if (wr_en) d.slot_ctl[idx] = bus_wdata[CTL_W-1:0];
                if (rd_en) d.rdata = DATA_W'(q.slot_ctl[idx]);
            end
            ACC_DEF: begin
                if (wr_en) d.def_addr = bus_wdata;
                if (rd_en) d.rdata = q.def_addr;
            end
            ACC_VEC: begin
                if (wr_en && (q.cur != IDLE)) begin
                    d.cur = q.hist[q.cur];
                end
                if (rd_en) begin
                    if (scan_hit) begin
                        d.hist[scan_lvl] = q.cur;
                        d.cur            = scan_lvl;
                    end
                    if (new_lvl >= LVL_W'(NUM_SLOTS))
                        d.rdata = q.def_addr;
                    else
                        d.rdata = q.slot_addr[new_lvl[SLOT_W-1:0]];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.cur <= IDLE;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = q.rdata;
    assign irq_o     = q.irq;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cur <= IDLE); // R5
    AST_ACK_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vec |=> (q.cur <= $past(q.cur))); // R7
    AST_EOI_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vec && q.cur != IDLE) |=> (q.cur > $past(q.cur))); // R8
    AST_EOI_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vec && q.cur == IDLE) |=> (q.cur == IDLE)); // R8
    AST_TOP_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cur == '0) |=> !irq_o); // R3
    AST_IDLE_ANY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cur == IDLE && (|pend_i) && !bus_en) |=> irq_o); // R4
endmodule

// File: tb/test_vic_nest_ctrl.sv
module test_vic_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pend_i = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    always #4 clk = ~clk;

    vic_nest_ctrl i_vic_nest_ctrl (
        .clk, .rst_n, .pend_i, .bus_en, .bus_we, .bus_addr,
        .bus_wdata, .bus_rdata, .irq_o
    );

    int total = 0;
    int bad   = 0;

    // reference model
    logic [7:0]  m_ctl [16];
    logic [31:0] m_addr [16];
    logic [31:0] m_def;
    int          m_cur;
    int          m_hist [17];

    function automatic logic [31:0] lmask(int lvl);
        logic [31:0] acc = '0;
        if (lvl >= 17) return '1;
        for (int j = 0; j < lvl; j++)
            if (m_ctl[j][5]) acc |= (32'd1 << m_ctl[j][4:0]);
        return acc;
    endfunction

    function automatic logic exp_irq();
        return |(pend_i & lmask(m_cur));
    endfunction

    function automatic logic [31:0] model_ack();
        int i;
        for (i = 0; i < m_cur; i++)
            if (|(pend_i & lmask(i + 1))) break;
        if (i < m_cur) begin
            m_hist[i] = m_cur;
            m_cur = i;
        end
        return (m_cur >= 16) ? m_def : m_addr[m_cur];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        if (a >= 12'h100 && a < 12'h140) m_addr[a[5:2]] = v;
        else if (a >= 12'h200 && a < 12'h240) m_ctl[a[5:2]] = v[7:0];
        else if (a == 12'h034) m_def = v;
        else if (a == 12'h030 && m_cur < 17) m_cur = m_hist[m_cur];
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        v = bus_rdata;
    endtask

    task automatic ack_chk(string req);
        logic [31:0] v, e;
        e = model_ack();
        rd(12'h030, v);
        chk(req, v, e);
    endtask

    task automatic settle_irq(string req);
        @(negedge clk);
        chk(req, 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic set_pend(logic [31:0] p);
        @(negedge clk);
        pend_i = p;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 16; k++) begin m_ctl[k] = '0; m_addr[k] = '0; end
        for (int k = 0; k < 17; k++) m_hist[k] = 17;
        m_def = '0; m_cur = 17;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h100, v); chk("R1 slot0 addr", v, 0);
        rd(12'h214, v); chk("R1 slot5 ctl", v, 0);
        rd(12'h034, v); chk("R1 default", v, 0);
        chk("R1 irq", 32'(irq_o), 0);
        ack_chk("R1 R6 idle ack");

        // R2 readback
        wr(12'h13C, 32'hDEADBEEF); rd(12'h13C, v); chk("R2 slot15 addr", v, 32'hDEADBEEF);
        wr(12'h204, 32'hFFFFFF27); rd(12'h204, v); chk("R2 ctl byte only", v, 32'h27);
        // R11 unmapped
        wr(12'h050, 32'h1234); rd(12'h050, v); chk("R11 unmapped read", v, 0);
        rd(12'h240, v); chk("R11 beyond ctl", v, 0);
        rd(12'h204, v); chk("R11 no side write", v, 32'h27);

        // directed layout
        wr(12'h100, 32'hA000_0000); wr(12'h200, 32'h23); // slot0 src3
        wr(12'h104, 32'hA000_0001); wr(12'h204, 32'h27); // slot1 src7
        wr(12'h108, 32'hA000_0002); wr(12'h208, 32'h23); // slot2 src3 dup
        wr(12'h10C, 32'hA000_0003); wr(12'h20C, 32'h09); // slot3 disabled src9
        wr(12'h034, 32'hD000_0000);

        set_pend(32'h200);          settle_irq("R4 idle unvectored");
        ack_chk("R5 R9 disabled slot -> default");
        settle_irq("R9 level16 masks src9");
        set_pend(32'h280);          settle_irq("R3 src7 outranks level16");
        ack_chk("R5 ack slot1");
        settle_irq("R3 level1 quiet");
        ack_chk("R7 no preempt returns slot1");
        set_pend(32'h288);          settle_irq("R3 src3 outranks level1");
        ack_chk("R9 dup src -> slot0");
        settle_irq("R3 level0 quiet");
        wr(12'h030, 32'hFFFF_FFFF); settle_irq("R8 back to level1");
        ack_chk("R8 reack slot0");
        wr(12'h030, 0); wr(12'h030, 0); wr(12'h030, 0);
        set_pend(0);                settle_irq("R8 idle");
        wr(12'h030, 0);             settle_irq("R8 idle write no effect");
        ack_chk("R6 idle empty -> default");

        // R10 mask change timing
        set_pend(32'h080); ack_chk("R10 setup slot1");
        set_pend(32'h020); settle_irq("R10 src5 unranked");
        wr(12'h200, 32'h25);
        chk("R10 irq not yet", 32'(irq_o), 0);
        @(negedge clk);
        chk("R10 irq follows", 32'(irq_o), 1);
        wr(12'h200, 32'h23);
        wr(12'h030, 0);
        set_pend(0); settle_irq("R10 restore");

        // random phase
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 9);
            if (op < 3) begin
                set_pend(32'($urandom_range(0, 1023)));
                settle_irq("R3 R4 random pend");
            end else if (op < 6) begin
                ack_chk("R5 R7 random ack");
                settle_irq("R3 after ack");
            end else if (op < 8) begin
                wr(12'h030, $urandom);
                settle_irq("R8 after eoi");
            end else begin
                int s = $urandom_range(0, 5);
                wr(12'h200 + 12'(s * 4), {$urandom} & 32'hFF & ~32'h18 | 32'($urandom_range(0, 1)) << 5);
                settle_irq("R10 after reprogram");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule